// File: doc/BRIEF.md
# RTC Alarm Comparator with Wildcard Fields

This block decides when a real-time clock alarm goes off. It keeps five stored alarm values: seconds, minutes, hours, day of month and month. Each time the timekeeping chain finishes its one-second advance, it pulses an update-done strobe. In that cycle the block compares the current time fields with the stored values. When all five agree, it sets a sticky alarm flag. The same flag drives a separate wake-up output for an external power-management controller. An interrupt request follows the flag when the host has enabled it.

A stored value whose two top bits are both 1 is a wildcard. No valid time code has that pattern, so the field matches any current value. The set of fields left as wildcards sets the repeat period:
- Only seconds and minutes real: the alarm repeats each hour.
- Seconds, minutes and hours real: it repeats each day.
- All five real: it is a one-shot alarm.

The host loads the alarm fields and the interrupt enable through a simple write port. It acknowledges the alarm with a clear strobe.

Top module: `rtc_alarm_match`

## Requirements
- R1: The comparison is made only in a cycle where `upd_done` is 1. A matching time without the strobe never sets the flag.
- R2: The flag is set only when all five fields match. One mismatching field blocks the set.
- R3: Once set, `alarm_flag` stays 1 until a cycle with `clr_flag` = 1 and no new match. A further match while it is set leaves it at 1.
- R4: `wake_out` equals `alarm_flag` in every cycle.
- R5: `irq` is 1 exactly when `alarm_flag` is 1 and the interrupt enable (control bit 0) is 1. Clearing either one drops `irq` in the following cycle.
- R6: A stored field with bits 7:6 = 2'b11 matches any current value of that field. Hourly and daily alarms follow from the chosen wildcards.
- R7: A stored field that is not a wildcard must equal the current value on all 8 bits. For example, a stored 8'h85 does not match a current 8'h05.
- R8: When `upd_done` with a full match and `clr_flag` occur in the same cycle, the set wins and the flag is 1 afterwards.
- R9: A host write in the same cycle as `upd_done` takes effect only after that cycle. That comparison uses the value held before the write.
- R10: `wr_sel` selects the target register. The codes are 0 seconds, 1 minutes, 2 hours, 3 day, 4 month and 5 control (bit 0 = interrupt enable). Codes 6 and 7 change nothing.
- R11: After reset, `alarm_flag`, `wake_out` and `irq` are 0. All alarm fields and the enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_done | input | 1 | One-cycle strobe: the time update has completed |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hr | input | 8 | Current hours |
| cur_day | input | 8 | Current day of month |
| cur_mon | input | 8 | Current month |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Target register of the write |
| wr_data | input | 8 | Write data |
| clr_flag | input | 1 | Host clear of the alarm flag |
| alarm_flag | output | 1 | Sticky alarm status flag |
| wake_out | output | 1 | Alarm signal to the wake-up controller |
| irq | output | 1 | Interrupt request |

## Verification
Two activities can land in the same cycle: a host acknowledge and an update that matches again. The same holds for a host rewrite of an alarm field and the update that compares against it. The bench provokes both by driving `clr_flag` or `wr_en` in the very cycle that carries `upd_done` with a time equal to the alarm. A reference model then predicts the flag. For the clear collision the flag must stay 1. For the write collision the old stored value must decide the match, and the new value must act only on the next update.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 5;
  localparam int SEL_W      = 3;
  localparam logic [1:0] WILD_CODE = 2'b11;

  // top two bits both set: a code no time value uses
  function automatic logic is_wild(input logic [FIELD_W-1:0] v);
    return v[FIELD_W-1 -: 2] == WILD_CODE;
  endfunction

  function automatic logic field_hit(input logic [FIELD_W-1:0] stored,
                                     input logic [FIELD_W-1:0] now);
    return is_wild(stored) || (stored == now);
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int W  = FIELD_W,
  parameter int SW = SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_sel,
  input  logic [W-1:0]         wr_data,
  output logic [NF-1:0][W-1:0] alarm_vals,
  output logic                 irq_en
);
  localparam logic [SW-1:0] CTL_SEL = SW'(NF);

  logic [W-1:0] field_q [NF];

  for (genvar i = 0; i < NF; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)
        field_q[i] <= '0;
      else if (wr_en && wr_sel == SW'(i))
        field_q[i] <= wr_data;
    end
    assign alarm_vals[i] = field_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq_en <= 1'b0;
    else if (wr_en && wr_sel == CTL_SEL)
      irq_en <= wr_data[0];
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int W  = FIELD_W
) (
  input  logic [NF-1:0][W-1:0] alarm_vals,
  input  logic [NF-1:0][W-1:0] cur_vals,
  output logic [NF-1:0]        hit_vec,
  output logic                 full_match
);
  for (genvar i = 0; i < NF; i++) begin : g_hit
    assign hit_vec[i] = field_hit(alarm_vals[i], cur_vals[i]);
  end
  assign full_match = &hit_vec;
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_done,
  input  logic full_match,
  input  logic clr_flag,
  input  logic irq_en,
  output logic set_evt,
  output logic flag_q,
  output logic irq
);
  logic flag_d;

  assign set_evt = upd_done && full_match;

  always_comb begin
    flag_d = flag_q;
    if (set_evt)       flag_d = 1'b1;  // set has priority over clear
    else if (clr_flag) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq = flag_q && irq_en;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_done,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hr,
  input  logic [FIELD_W-1:0] cur_day,
  input  logic [FIELD_W-1:0] cur_mon,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic               clr_flag,
  output logic               alarm_flag,
  output logic               wake_out,
  output logic               irq
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_vals;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] cur_vals;
  logic [NUM_FIELDS-1:0]              hit_vec;
  logic                               full_match;
  logic                               set_evt;
  logic                               irq_en;

  // index 0 = seconds ... index 4 = month, same as the write selects
  assign cur_vals = {cur_mon, cur_day, cur_hr, cur_min, cur_sec};

  rtc_alarm_regs #(.NF(NUM_FIELDS), .W(FIELD_W), .SW(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .alarm_vals(alarm_vals), .irq_en(irq_en)
  );

  rtc_alarm_cmp #(.NF(NUM_FIELDS), .W(FIELD_W)) u_cmp (
    .alarm_vals(alarm_vals), .cur_vals(cur_vals),
    .hit_vec(hit_vec), .full_match(full_match)
  );

  rtc_alarm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .full_match(full_match),
    .clr_flag(clr_flag), .irq_en(irq_en), .set_evt(set_evt),
    .flag_q(alarm_flag), .irq(irq)
  );

  assign wake_out = alarm_flag;
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
  input logic clk,
  input logic rst_n,
  input logic upd_done,
  input logic clr_flag,
  input logic full_match,
  input logic irq_en,
  input logic alarm_flag,
  input logic wake_out,
  input logic irq
);
  // R1
  flag_needs_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(upd_done));

  // R2
  no_set_without_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !(upd_done && full_match)) |=> !alarm_flag);

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !clr_flag) |=> alarm_flag);

  // R4
  wake_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out == alarm_flag);

  // R5
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (alarm_flag && irq_en));

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && full_match && clr_flag) |=> alarm_flag);
endmodule

bind rtc_alarm_match rtc_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .clr_flag(clr_flag),
  .full_match(full_match), .irq_en(irq_en), .alarm_flag(alarm_flag),
  .wake_out(wake_out), .irq(irq)
);

// File: tb/rtc_alarm_match_test.sv
module rtc_alarm_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_done = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hr = '0, cur_day = '0, cur_mon = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       clr_flag = 1'b0;
  logic       alarm_flag, wake_out, irq;

  int checks = 0;
  int errors = 0;

  // reference model
  logic [7:0] m_alarm [5];
  logic       m_en = 1'b0;
  logic       m_flag = 1'b0;

  logic [1:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;  // 50 MHz

  rtc_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .upd_done(upd_done),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .cur_day(cur_day), .cur_mon(cur_mon),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .clr_flag(clr_flag), .alarm_flag(alarm_flag), .wake_out(wake_out), .irq(irq)
  );

  function automatic bit model_hit(input logic [7:0] a, input logic [7:0] c);
    return (a >= 8'hC0) || (a == c);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, pushes the expected outputs after the edge
  task automatic tick(input bit upd, input logic [7:0] s, m, h, d, mo,
                      input bit we, input logic [2:0] sel, input logic [7:0] data,
                      input bit clr, input string tag);
    bit hit;
    @(negedge clk);
    upd_done = upd; cur_sec = s; cur_min = m; cur_hr = h; cur_day = d; cur_mon = mo;
    wr_en = we; wr_sel = sel; wr_data = data; clr_flag = clr;
    hit = model_hit(m_alarm[0], s) && model_hit(m_alarm[1], m) &&
          model_hit(m_alarm[2], h) && model_hit(m_alarm[3], d) &&
          model_hit(m_alarm[4], mo);
    if (upd && hit) m_flag = 1'b1;
    else if (clr)   m_flag = 1'b0;
    if (we && sel < 3'd5) m_alarm[sel] = data;
    else if (we && sel == 3'd5) m_en = data[0];
    exp_q.push_back({m_flag, m_flag & m_en});
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data, input string tag);
    tick(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, sel, data, 1'b0, tag);
  endtask

  task automatic upd(input logic [7:0] s, m, h, d, mo, input bit clr, input string tag);
    tick(1'b1, s, m, h, d, mo, 1'b0, 3'd0, 8'h00, clr, tag);
  endtask

  task automatic clr(input string tag);
    tick(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1, tag);
  endtask

  // monitor: compares after each edge, away from it
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(alarm_flag == e[1], {t, " flag"}, alarm_flag, e[1]);
      check(irq == e[0], {t, " irq"}, irq, e[0]);
      // R4
      check(wake_out == alarm_flag, "R4 wake", wake_out, alarm_flag);
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 5; i++) m_alarm[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #5;
    // R11 reset state
    check(alarm_flag == 1'b0, "R11 flag", alarm_flag, 0);
    check(wake_out == 1'b0, "R11 wake", wake_out, 0);
    check(irq == 1'b0, "R11 irq", irq, 0);

    // R10 load one-shot alarm 12:30:45 day 15 month 6, enable irq
    wr(3'd0, 8'd45, "R10 wr sec");
    wr(3'd1, 8'd30, "R10 wr min");
    wr(3'd2, 8'd12, "R10 wr hr");
    wr(3'd3, 8'd15, "R10 wr day");
    wr(3'd4, 8'd6,  "R10 wr mon");
    wr(3'd5, 8'h01, "R10 wr ctl");
    // R1 matching time without strobe
    tick(1'b0, 8'd45, 8'd30, 8'd12, 8'd15, 8'd6, 1'b0, 3'd0, 8'h00, 1'b0, "R1 no strobe");
    // R2 one field off
    upd(8'd45, 8'd31, 8'd12, 8'd15, 8'd6, 1'b0, "R2 minute off");
    upd(8'd45, 8'd30, 8'd12, 8'd15, 8'd7, 1'b0, "R2 month off");
    // R3 / R5 exact match
    upd(8'd45, 8'd30, 8'd12, 8'd15, 8'd6, 1'b0, "R3 set");
    upd(8'd46, 8'd30, 8'd12, 8'd15, 8'd6, 1'b0, "R3 held");
    upd(8'd45, 8'd30, 8'd12, 8'd15, 8'd6, 1'b0, "R3 rematch");
    // R5 enable off and back on
    wr(3'd5, 8'h00, "R5 irq off");
    wr(3'd5, 8'h01, "R5 irq on");
    clr("R3 clear");
    // R10 codes 6 and 7 are ignored
    wr(3'd6, 8'h00, "R10 sel6");
    wr(3'd7, 8'h00, "R10 sel7");
    upd(8'd45, 8'd30, 8'd12, 8'd15, 8'd6, 1'b0, "R10 unchanged");
    clr("R3 clear2");

    // R7 full 8-bit compare with top bits 10
    wr(3'd0, 8'h85, "R7 wr sec");
    wr(3'd1, 8'h1E, "R7 wr min");
    wr(3'd2, 8'hC0, "R6 wr hr wild");
    wr(3'd3, 8'hFF, "R6 wr day wild");
    wr(3'd4, 8'hC7, "R6 wr mon wild");
    upd(8'h05, 8'h1E, 8'd3, 8'd9, 8'd2, 1'b0, "R7 low bits only");
    upd(8'h85, 8'h1E, 8'd3, 8'd9, 8'd2, 1'b0, "R7 exact");
    clr("R7 clear");

    // R6 hourly alarm at mm:ss = 20:10
    wr(3'd0, 8'd10, "R6 wr sec");
    wr(3'd1, 8'd20, "R6 wr min");
    upd(8'd10, 8'd20, 8'd1, 8'd4, 8'd11, 1'b0, "R6 hour 1");
    clr("R6 clear");
    upd(8'd10, 8'd20, 8'd2, 8'd4, 8'd11, 1'b0, "R6 hour 2");
    clr("R6 clear b");
    upd(8'd10, 8'd21, 8'd2, 8'd4, 8'd11, 1'b0, "R6 wrong minute");
    // R6 daily at 07:20:10
    wr(3'd2, 8'd7, "R6 wr hr");
    upd(8'd10, 8'd20, 8'd8, 8'd5, 8'd11, 1'b0, "R6 daily wrong hour");
    upd(8'd10, 8'd20, 8'd7, 8'd5, 8'd11, 1'b0, "R6 daily hit");

    // R8 clear and match collide: set wins
    upd(8'd10, 8'd20, 8'd7, 8'd6, 8'd11, 1'b1, "R8 set wins");
    upd(8'd11, 8'd20, 8'd7, 8'd6, 8'd11, 1'b1, "R8 clear with miss");

    // R9 write in the update cycle: old value decides
    tick(1'b1, 8'd10, 8'd20, 8'd7, 8'd1, 8'd1, 1'b1, 3'd0, 8'd33, 1'b0, "R9 old value hits");
    clr("R9 clear");
    upd(8'd10, 8'd20, 8'd7, 8'd1, 8'd1, 1'b0, "R9 old value gone");
    upd(8'd33, 8'd20, 8'd7, 8'd1, 8'd1, 1'b0, "R9 new value hits");

    // R5 flag set with enable cleared: no irq
    wr(3'd5, 8'h00, "R5 en off flag set");
    tick(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, "R5 idle");

    @(negedge clk);
    upd_done = 1'b0; wr_en = 1'b0; clr_flag = 1'b0;
    repeat (2) @(posedge clk);
    #6;
    summary();
  end
endmodule